// File: doc/BRIEF.md
# Transmit Rate-Change Reset Sequencer

This block changes the transmit data rate of one serial transceiver channel while the link is running, and keeps the transmit digital logic in reset for the whole change. A request carries a new 2-bit rate code. The sequencer first asserts the transmit reset. It then presents the code to the rate-select register of an external reconfiguration controller and sends a one-cycle commit strobe. It waits for the controller's busy signal to rise and then to fall, and only then releases the reset.

After a synchronous system reset, the transmit reset is held for a fixed start-up interval. Requests arrive as single-cycle qualified strobes and are taken only while the sequencer reports ready. If the controller never raises busy within a run-time limit, the sequencer gives up: it releases the reset, returns to ready and records a sticky error. The same sequence drives every lane of a 1, 2, 4 or 8 lane channel.

Top module: `txrate_seq`

## Requirements
- R1: While `rst` is high and afterwards, `tx_hold_rst` is all ones, and `seq_ready`, `seq_err`, `seq_done`, `cfg_wr` and `cfg_commit` are 0. `tx_hold_rst` falls and `seq_ready` rises after exactly INIT_CYCLES (default 16) rising edges with `rst` low.
- R2: `rate_req` is ignored whenever `seq_ready` is 0. This covers the start-up interval and a sequence in progress. An ignored request causes no register write and no reset activity.
- R3: A request taken while `seq_ready` is 1 makes every bit of `tx_hold_rst` high in the next cycle, before any register write.
- R4: The cycle after `tx_hold_rst` rises, `cfg_wr` is high for exactly one cycle, and `cfg_rate` holds the 2-bit code sampled with the request.
- R5: `cfg_commit` is a single-cycle pulse in the cycle right after `cfg_wr`, once for each request.
- R6: After the commit, `tx_hold_rst` stays high until busy has been seen high and then low. Release comes 2 cycles after the last cycle in which `cfg_busy` was high.
- R7: `seq_done` is a one-cycle pulse in the cycle in which `tx_hold_rst` first reads low after a sequence. `seq_ready` is 1 in the following cycle.
- R8: With limit N on `busy_tmo`, a busy that rises in any of the first N+1 cycles after the commit cycle is accepted. If busy stays low for all N+1 cycles, the block releases the reset and pulses `seq_done` N+2 cycles after the commit cycle, and sets `seq_err`.
- R9: `seq_err` stays 1 through later successful sequences until `rst` clears it.
- R10: All LANES bits of `tx_hold_rst` carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_req | input | 1 | Rate-change request strobe |
| rate_req_code | input | 2 | Requested 2-bit rate code |
| busy_tmo | input | TMO_W | Busy-rise limit N |
| cfg_busy | input | 1 | Busy from the reconfiguration controller |
| tx_hold_rst | output | LANES | Transmit digital reset, one per lane |
| cfg_wr | output | 1 | Rate-select register write enable |
| cfg_rate | output | 2 | Rate code presented with the write |
| cfg_commit | output | 1 | Commit strobe to the controller |
| seq_done | output | 1 | Sequence completion pulse |
| seq_ready | output | 1 | Sequencer idle and accepting requests |
| seq_err | output | 1 | Sticky busy-timeout flag |

## Verification
The bound checker watches the following on every cycle:
- the ordering from request to reset to write to commit;
- the single-cycle width of the commit and done pulses;
- that done only follows a cycle with busy low;
- the persistence of the error flag;
- that the lanes agree;
- the post-reset state.

The bench scenarios cover what the checker cannot see:
- the exact 16-cycle start-up release;
- that the right rate code is written;
- the N versus N+1 busy-delay boundary, and the exact timeout latency;
- that requests during start-up or mid-sequence are discarded;
- that reset clears the error.

// File: rtl/txrate_pkg.sv
package txrate_pkg;

    typedef logic [1:0] rate_code_t;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_HOLD,
        ST_WRITE,
        ST_COMMIT,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_RELEASE
    } seq_state_e;

    typedef struct packed {
        logic hold_rst;
        logic wr_en;
        logic commit;
        logic done;
        logic ready;
    } seq_ctrl_t;

    function automatic seq_ctrl_t decode_state(seq_state_e s);
        seq_ctrl_t c;
        c.hold_rst = (s != ST_IDLE) && (s != ST_RELEASE);
        c.wr_en    = (s == ST_WRITE);
        c.commit   = (s == ST_COMMIT);
        c.done     = (s == ST_RELEASE);
        c.ready    = (s == ST_IDLE);
        return c;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txrate_timer.sv
module txrate_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/txrate_fsm.sv
module txrate_fsm
    import txrate_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TMO_W       = 8,
    parameter int INIT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_req,
    input  logic             cfg_busy,
    input  logic [TMO_W-1:0] busy_tmo,
    input  logic [CNT_W-1:0] count,
    output seq_state_e       state,
    output logic             timer_clr,
    output logic             timer_inc,
    output logic             accept,
    output logic             tmo_hit
);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);

    seq_state_e       nxt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(busy_tmo);

    always_comb begin
        nxt       = state;
        timer_clr = 1'b0;
        timer_inc = 1'b0;
        accept    = 1'b0;
        tmo_hit   = 1'b0;
        unique case (state)
            ST_INIT: begin
                if (count == INIT_LAST) begin
                    nxt       = ST_IDLE;
                    timer_clr = 1'b1;
                end else begin
                    timer_inc = 1'b1;
                end
            end
            ST_IDLE: begin
                if (rate_req) begin
                    accept = 1'b1;
                    nxt    = ST_HOLD;
                end
            end
            ST_HOLD:   nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_COMMIT;
            ST_COMMIT: begin
                nxt       = ST_WAIT_HI;
                timer_clr = 1'b1;
            end
            ST_WAIT_HI: begin
                if (cfg_busy) begin
                    nxt = ST_WAIT_LO;
                end else if (count == limit) begin
                    nxt     = ST_RELEASE;
                    tmo_hit = 1'b1;
                end else begin
                    timer_inc = 1'b1;
                end
            end
            ST_WAIT_LO: begin
                if (!cfg_busy) nxt = ST_RELEASE;
            end
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_INIT;
        else     state <= nxt;
    end
endmodule

// File: rtl/txrate_regs.sv
module txrate_regs
    import txrate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  rate_code_t code_in,
    input  logic       tmo_hit,
    output rate_code_t code_q,
    output logic       err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) code_q <= code_in;
            if (tmo_hit) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/txrate_seq.sv
module txrate_seq
    import txrate_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int TMO_W       = 8,
    parameter int INIT_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_req,
    input  logic [1:0]       rate_req_code,
    input  logic [TMO_W-1:0] busy_tmo,
    input  logic             cfg_busy,
    output logic [LANES-1:0] tx_hold_rst,
    output logic             cfg_wr,
    output logic [1:0]       cfg_rate,
    output logic             cfg_commit,
    output logic             seq_done,
    output logic             seq_ready,
    output logic             seq_err
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam int CNT_W  = max_int(TMO_W, INIT_W);

    seq_state_e       state;
    seq_ctrl_t        ctrl;
    logic [CNT_W-1:0] count;
    logic             timer_clr;
    logic             timer_inc;
    logic             accept;
    logic             tmo_hit;
    rate_code_t       code_q;

    txrate_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (timer_clr),
        .inc   (timer_inc),
        .count (count)
    );

    txrate_fsm #(
        .CNT_W       (CNT_W),
        .TMO_W       (TMO_W),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rate_req  (rate_req),
        .cfg_busy  (cfg_busy),
        .busy_tmo  (busy_tmo),
        .count     (count),
        .state     (state),
        .timer_clr (timer_clr),
        .timer_inc (timer_inc),
        .accept    (accept),
        .tmo_hit   (tmo_hit)
    );

    txrate_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .code_in (rate_req_code),
        .tmo_hit (tmo_hit),
        .code_q  (code_q),
        .err_q   (seq_err)
    );

    assign ctrl       = decode_state(state);
    assign cfg_wr     = ctrl.wr_en;
    assign cfg_rate   = code_q;
    assign cfg_commit = ctrl.commit;
    assign seq_done   = ctrl.done;
    assign seq_ready  = ctrl.ready;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tx_hold_rst[g] = ctrl.hold_rst;
    end
endmodule

// File: rtl/txrate_seq_chk.sv
module txrate_seq_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rate_req,
    input logic             cfg_busy,
    input logic [LANES-1:0] tx_hold_rst,
    input logic             cfg_wr,
    input logic             cfg_commit,
    input logic             seq_done,
    input logic             seq_ready,
    input logic             seq_err
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&tx_hold_rst && !seq_err && !seq_ready && !cfg_wr && !cfg_commit));

    assert_hold_first_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_ready && rate_req) |=> (&tx_hold_rst && !cfg_wr));

    assert_write_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> ($past(&tx_hold_rst) && !$past(cfg_wr)));

    assert_commit_follows_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> cfg_commit);

    assert_commit_single_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_commit |=> !cfg_commit);

    assert_release_after_busy_low_R6: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !$past(cfg_busy));

    assert_done_then_ready_R7: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (!seq_done && seq_ready));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    assert_lanes_agree_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_hold_rst == '0) || (tx_hold_rst == '1));
endmodule

bind txrate_seq txrate_seq_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rate_req    (rate_req),
    .cfg_busy    (cfg_busy),
    .tx_hold_rst (tx_hold_rst),
    .cfg_wr      (cfg_wr),
    .cfg_commit  (cfg_commit),
    .seq_done    (seq_done),
    .seq_ready   (seq_ready),
    .seq_err     (seq_err)
);

// File: tb/txrate_seq_bench.sv
module txrate_seq_bench;
    localparam int LANES = 4;
    localparam int TMO_W = 8;
    localparam int INIT_CYCLES = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rate_req = 1'b0;
    logic [1:0]       rate_req_code = 2'd0;
    logic [TMO_W-1:0] busy_tmo = '0;
    logic             cfg_busy = 1'b0;
    logic [LANES-1:0] tx_hold_rst;
    logic             cfg_wr;
    logic [1:0]       cfg_rate;
    logic             cfg_commit;
    logic             seq_done;
    logic             seq_ready;
    logic             seq_err;

    int n_checks = 0;
    int n_errs   = 0;

    // controller model settings
    int m_dly = 0;
    int m_len = 1;
    int m_st  = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    txrate_seq #(.LANES(LANES), .TMO_W(TMO_W), .INIT_CYCLES(INIT_CYCLES)) u_txrate_seq (
        .clk (clk), .rst (rst), .rate_req (rate_req), .rate_req_code (rate_req_code),
        .busy_tmo (busy_tmo), .cfg_busy (cfg_busy), .tx_hold_rst (tx_hold_rst),
        .cfg_wr (cfg_wr), .cfg_rate (cfg_rate), .cfg_commit (cfg_commit),
        .seq_done (seq_done), .seq_ready (seq_ready), .seq_err (seq_err)
    );

    // reconfiguration controller model, updated 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (seq_done || rst) begin
            m_st = 0;
            cfg_busy = 1'b0;
        end else begin
            case (m_st)
                0: if (cfg_commit) begin m_st = 1; m_cnt = m_dly; end
                1: if (m_cnt == 0) begin cfg_busy = 1'b1; m_st = 2; m_cnt = m_len; end
                   else m_cnt = m_cnt - 1;
                2: if (m_cnt <= 1) begin cfg_busy = 1'b0; m_st = 0; end
                   else m_cnt = m_cnt - 1;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // vector: rate[26:25] dly[24:17] len[16:9] tmo[8:1] err_after[0]
    localparam int NV = 7;
    localparam logic [26:0] VEC [NV] = '{
        {2'd1, 8'd0,   8'd1, 8'd4, 1'b0},
        {2'd2, 8'd3,   8'd5, 8'd4, 1'b0},
        {2'd3, 8'd4,   8'd2, 8'd4, 1'b0},
        {2'd0, 8'd0,   8'd9, 8'd0, 1'b0},
        {2'd2, 8'd5,   8'd1, 8'd4, 1'b1},
        {2'd1, 8'd1,   8'd3, 8'd2, 1'b1},
        {2'd3, 8'd200, 8'd1, 8'd3, 1'b1}
    };

    task automatic run_seq(input logic [1:0] rate, input int dly, input int len,
                           input int tmo, input bit exp_err, input bit hold_req);
        int we_cyc = -1, cm_cyc = -1, cm_n = 0, we_n = 0, done_cyc = -1, last_busy = -1;
        int we_rate = 0;
        bit hold_ok = 1'b1;
        m_dly = dly; m_len = len; busy_tmo = TMO_W'(tmo);
        @(negedge clk);
        while (!seq_ready) @(negedge clk);
        rate_req = 1'b1; rate_req_code = rate;
        @(negedge clk);
        if (hold_req) rate_req_code = ~rate; else rate_req = 1'b0;
        // R3: reset asserted first, no write yet
        chk(tx_hold_rst == '1 && !cfg_wr, "R3", int'(tx_hold_rst), (1 << LANES) - 1);
        for (int c = 0; c < 400; c++) begin
            if (cfg_wr) begin we_n++; we_cyc = c; we_rate = int'(cfg_rate); end
            if (cfg_commit) begin cm_n++; cm_cyc = c; end
            if (cfg_busy) last_busy = c;
            if (seq_done) begin done_cyc = c; break; end
            if (tx_hold_rst != '1) hold_ok = 1'b0;
            @(negedge clk);
        end
        rate_req = 1'b0;
        chk(we_cyc == 1 && we_n == 1, "R4 write cycle", we_cyc, 1);
        chk(we_rate == int'(rate), "R4 rate code", we_rate, int'(rate));
        chk(cm_cyc == we_cyc + 1 && cm_n == 1, "R5 commit", cm_cyc, we_cyc + 1);
        chk(done_cyc > 0 && tx_hold_rst == '0, "R7 done with release", int'(tx_hold_rst), 0);
        chk(hold_ok, "R6 hold until release", int'(hold_ok), 1);
        if (dly > tmo) chk(done_cyc - cm_cyc == tmo + 2, "R8 timeout latency", done_cyc - cm_cyc, tmo + 2);
        else           chk(done_cyc - last_busy == 2, "R6 release after busy", done_cyc - last_busy, 2);
        chk(seq_err == exp_err, "R8/R9 err flag", int'(seq_err), int'(exp_err));
        @(negedge clk);
        chk(seq_ready && !seq_done, "R7 ready after done", int'(seq_ready), 1);
        if (hold_req) begin
            // R2: the request held during the sequence must not start another one
            int extra = 0;
            for (int c = 0; c < 8; c++) begin
                if (cfg_wr || tx_hold_rst != '0) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R2 mid-sequence request dropped", extra, 0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx_hold_rst == '1 && !seq_ready && !seq_err && !seq_done && !cfg_wr && !cfg_commit,
            "R1 reset state", int'(tx_hold_rst), (1 << LANES) - 1);
        rst = 1'b0;
        // R2: request during start-up interval
        rate_req = 1'b1; rate_req_code = 2'd3;
        repeat (2) @(negedge clk);
        rate_req = 1'b0;
        @(negedge clk);
        repeat (INIT_CYCLES - 4) @(posedge clk);
        @(negedge clk);
        chk(tx_hold_rst == '1 && !seq_ready, "R1 held before count", int'(seq_ready), 0);
        @(negedge clk);
        chk(tx_hold_rst == '0 && seq_ready, "R1 release after count", int'(tx_hold_rst), 0);
        begin
            int act = 0;
            for (int c = 0; c < 10; c++) begin
                if (cfg_wr || cfg_commit || tx_hold_rst != '0) act++;
                @(negedge clk);
            end
            chk(act == 0, "R2 start-up request ignored", act, 0);
        end
        // R10 lanes agree is also checked through R3/R7 full-vector compares
        chk(tx_hold_rst == '0 || tx_hold_rst == '1, "R10 lanes agree", int'(tx_hold_rst), 0);

        for (int i = 0; i < NV; i++) begin
            run_seq(VEC[i][26:25], int'(VEC[i][24:17]), int'(VEC[i][16:9]),
                    int'(VEC[i][8:1]), VEC[i][0], 1'b0);
        end

        // R2: request kept high during a sequence, error still sticky (R9)
        run_seq(2'd1, 2, 2, 8, 1'b1, 1'b1);

        // R9: reset clears the error
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!seq_err && tx_hold_rst == '1, "R9 err cleared by reset", int'(seq_err), 0);
        rst = 1'b0;
        repeat (INIT_CYCLES + 2) @(negedge clk);
        run_seq(2'd2, 1, 1, 3, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule